// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control unit of a 32-bit load/store processor that spends several clock cycles on each instruction. It is a Moore state machine. It reads the 6-bit major opcode held in the instruction register and the zero flag from the ALU. From its current state alone it drives every select and enable the shared datapath needs: PC update, memory address source, memory read and write, instruction capture, register write-back, ALU operand selection, ALU operation class and PC source.

Every instruction begins with the same two states. The first is a fetch, which reads memory at the PC and advances the PC by 4 through the ALU. The second is a decode, which reads both source registers and computes the branch target ahead of time. After decode, the instruction class picks its own path. A branch-if-equal and a jump finish in 3 cycles, a store and a register-register operation in 4, and a load in 5. The datapath, the register file, the memory and the ALU function decoder are outside this block.

Top module: `mcyc_ctrl`

## Requirements
- R1: A synchronous reset `rst` puts the machine in the fetch state. It stays in fetch for every cycle that `rst` is high, even in the middle of an instruction, and the fetch outputs appear on the cycle after the clock edge that saw `rst`.
- R2: In the fetch state, `mem_rd`, `ir_wr`, `pc_wr` and `pc_load` are 1, `alu_b_sel` is 01 (constant 4), and `alu_a_sel_reg` is 0 (PC). Every other output is 0, which gives `alu_op` 00 (add) and `pc_src` 00 (ALU result).
- R3: Fetch is always followed by decode. In decode, `alu_b_sel` is 11 (sign-extended offset shifted left by 2), `alu_a_sel_reg` is 0 and `alu_op` is 00. Every other output is 0.
- R4: A load word (opcode 100011) takes 5 cycles:
  - fetch, then decode;
  - address calculation, with `alu_a_sel_reg`=1 and `alu_b_sel`=10 (sign-extended offset);
  - memory read, with `mem_rd`=1 and `addr_sel_data`=1;
  - write-back, with `reg_wr`=1, `wb_sel_mem`=1 and `dst_sel_rd`=0.
- R5: A store word (opcode 101011) takes 4 cycles: fetch, decode, the same address calculation as R4, then a memory write with `mem_wr`=1 and `addr_sel_data`=1.
- R6: An R-type instruction (opcode 000000) takes 4 cycles:
  - fetch, then decode;
  - execute, with `alu_a_sel_reg`=1, `alu_b_sel`=00 (B register) and `alu_op`=10 (decode by function field);
  - write-back, with `reg_wr`=1 and `dst_sel_rd`=1.
- R7: A branch-if-equal (opcode 000100) takes 3 cycles: fetch, decode, then a compare state. In the compare state, `pc_wr_cond`=1, `alu_a_sel_reg`=1, `alu_b_sel`=00, `alu_op`=01 (subtract) and `pc_src`=01 (ALUOut). In that state, `pc_load` equals `alu_zero`.
- R8: A jump (opcode 000010) takes 3 cycles: fetch, decode, then a jump state with `pc_wr`=1, `pc_load`=1 and `pc_src`=10 (jump target).
- R9: Any other opcode returns to fetch immediately after decode, so it takes 2 cycles and writes nothing.
- R10: In every state, each output not named for that state is 0. `alu_zero` has no effect on any output outside the branch compare state. `pc_load` is the effective PC enable: `pc_wr`, or `pc_wr_cond` together with `alu_zero`.
- R11: `mem_rd` and `mem_wr` are never 1 together, and `reg_wr` is never 1 together with `mem_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Instruction bits 31..26 from the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write if ALU result is zero |
| pc_load | output | 1 | Effective PC enable |
| addr_sel_data | output | 1 | Memory address: 0 PC, 1 ALUOut |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register write |
| wb_sel_mem | output | 1 | Write-back data: 0 ALUOut, 1 memory data |
| reg_wr | output | 1 | Register file write |
| dst_sel_rd | output | 1 | Destination: 0 rt field, 1 rd field |
| alu_a_sel_reg | output | 1 | ALU A: 0 PC, 1 A register |
| alu_b_sel | output | 2 | ALU B: 00 B, 01 const 4, 10 offset, 11 offset<<2 |
| alu_op | output | 2 | 00 add, 01 subtract, 10 by function field |
| pc_src | output | 2 | 00 ALU result, 01 ALUOut, 10 jump target |

## Verification
The assertions assume that `opcode` comes from the instruction register and so stays constant from decode until the instruction returns to fetch. They also assume that `alu_zero` matters only in the branch compare state. The bench changes `opcode` only while the machine is in fetch. It moves `alu_zero` freely, including to 1 during loads, to show that the flag leaves the other states untouched. Reset is applied at start-up and again in the middle of a load.

// File: rtl/mcyc_ctrl.sv
`timescale 1ns/100ps
module mcyc_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic       alu_zero,
  output logic       pc_wr,
  output logic       pc_wr_cond,
  output logic       pc_load,
  output logic       addr_sel_data,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       ir_wr,
  output logic       wb_sel_mem,
  output logic       reg_wr,
  output logic       dst_sel_rd,
  output logic       alu_a_sel_reg,
  output logic [1:0] alu_b_sel,
  output logic [1:0] alu_op,
  output logic [1:0] pc_src
);
  localparam logic [5:0] OP_ALU = 6'b000000;
  localparam logic [5:0] OP_LD  = 6'b100011;
  localparam logic [5:0] OP_ST  = 6'b101011;
  localparam logic [5:0] OP_BEQ = 6'b000100;
  localparam logic [5:0] OP_JMP = 6'b000010;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_ADDR, S_LOAD, S_LOADWB,
    S_STORE, S_EXEC, S_ALUWB, S_BRANCH, S_JUMP
  } state_t;

  state_t st, st_nx;

  always_ff @(posedge clk) begin
    if (rst) st <= S_FETCH;
    else     st <= st_nx;
  end

  always_comb begin
    st_nx = S_FETCH;
    case (st)
      S_FETCH:  st_nx = S_DECODE;
      S_DECODE:
        case (opcode)
          OP_LD, OP_ST: st_nx = S_ADDR;
          OP_ALU:       st_nx = S_EXEC;
          OP_BEQ:       st_nx = S_BRANCH;
          OP_JMP:       st_nx = S_JUMP;
          default:      st_nx = S_FETCH;
        endcase
      S_ADDR:   st_nx = (opcode == OP_LD) ? S_LOAD : S_STORE;
      S_LOAD:   st_nx = S_LOADWB;
      S_EXEC:   st_nx = S_ALUWB;
      default:  st_nx = S_FETCH;
    endcase
  end

  assign pc_wr         = (st == S_FETCH) || (st == S_JUMP);
  assign pc_wr_cond    = (st == S_BRANCH);
  assign pc_load       = pc_wr || (pc_wr_cond && alu_zero);
  assign addr_sel_data = (st == S_LOAD) || (st == S_STORE);
  assign mem_rd        = (st == S_FETCH) || (st == S_LOAD);
  assign mem_wr        = (st == S_STORE);
  assign ir_wr         = (st == S_FETCH);
  assign wb_sel_mem    = (st == S_LOADWB);
  assign reg_wr        = (st == S_LOADWB) || (st == S_ALUWB);
  assign dst_sel_rd    = (st == S_ALUWB);
  assign alu_a_sel_reg = (st == S_ADDR) || (st == S_EXEC) || (st == S_BRANCH);

  always_comb begin
    case (st)
      S_FETCH:  alu_b_sel = 2'b01;
      S_DECODE: alu_b_sel = 2'b11;
      S_ADDR:   alu_b_sel = 2'b10;
      default:  alu_b_sel = 2'b00;
    endcase
  end

  assign alu_op = (st == S_EXEC)   ? 2'b10 :
                  (st == S_BRANCH) ? 2'b01 : 2'b00;
  assign pc_src = (st == S_JUMP)   ? 2'b10 :
                  (st == S_BRANCH) ? 2'b01 : 2'b00;
endmodule

// File: rtl/mcyc_ctrl_chk.sv
`timescale 1ns/100ps
module mcyc_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       alu_zero,
  input logic       pc_wr,
  input logic       pc_wr_cond,
  input logic       pc_load,
  input logic       addr_sel_data,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       ir_wr,
  input logic       wb_sel_mem,
  input logic       reg_wr,
  input logic       dst_sel_rd,
  input logic       alu_a_sel_reg,
  input logic [1:0] alu_b_sel,
  input logic [1:0] alu_op,
  input logic [1:0] pc_src
);
  logic rst_q = 1'b0;

  always @(posedge clk) begin
    if (rst_q)
      AST_RESET_FETCH: assert (ir_wr && mem_rd && pc_wr && !mem_wr && !reg_wr); // R1
    rst_q <= rst;
  end

  AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (rst)
    ir_wr |=> (alu_b_sel == 2'b11 && !alu_a_sel_reg && !ir_wr && !pc_wr)); // R3
  AST_LOAD_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && addr_sel_data) |=> (reg_wr && wb_sel_mem && !dst_sel_rd)); // R4
  AST_STORE_ENDS: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> ir_wr); // R5
  AST_EXEC_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
    (alu_op == 2'b10) |=> (reg_wr && dst_sel_rd && !wb_sel_mem)); // R6
  AST_BRANCH_FORM: assert property (@(posedge clk) disable iff (rst)
    pc_wr_cond |-> (!pc_wr && alu_op == 2'b01 && pc_src == 2'b01)); // R7
  AST_BRANCH_ENDS: assert property (@(posedge clk) disable iff (rst)
    pc_wr_cond |=> ir_wr); // R7
  AST_JUMP_ENDS: assert property (@(posedge clk) disable iff (rst)
    (pc_src == 2'b10) |=> ir_wr); // R8
  AST_PC_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!pc_wr && !pc_wr_cond) |-> !pc_load); // R10
  AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R11
  AST_WRITE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && mem_wr)); // R11

  logic unused_ok;
  assign unused_ok = alu_zero;
endmodule

bind mcyc_ctrl mcyc_ctrl_chk i_chk (.*);

// File: tb/test_mcyc_ctrl.sv
`timescale 1ns/100ps
module test_mcyc_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = 6'b0;
  logic alu_zero = 1'b0;
  logic pc_wr, pc_wr_cond, pc_load, addr_sel_data, mem_rd, mem_wr, ir_wr;
  logic wb_sel_mem, reg_wr, dst_sel_rd, alu_a_sel_reg;
  logic [1:0] alu_b_sel, alu_op, pc_src;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  mcyc_ctrl i_mcyc_ctrl (.*);

  localparam logic [16:0] V_FETCH = 17'b1_0_1_0_1_0_1_0_0_0_0_01_00_00;
  localparam logic [16:0] V_DEC   = 17'b0_0_0_0_0_0_0_0_0_0_0_11_00_00;
  localparam logic [16:0] V_ADDR  = 17'b0_0_0_0_0_0_0_0_0_0_1_10_00_00;
  localparam logic [16:0] V_LOAD  = 17'b0_0_0_1_1_0_0_0_0_0_0_00_00_00;
  localparam logic [16:0] V_LWB   = 17'b0_0_0_0_0_0_0_1_1_0_0_00_00_00;
  localparam logic [16:0] V_STORE = 17'b0_0_0_1_0_1_0_0_0_0_0_00_00_00;
  localparam logic [16:0] V_EXEC  = 17'b0_0_0_0_0_0_0_0_0_0_1_00_10_00;
  localparam logic [16:0] V_AWB   = 17'b0_0_0_0_0_0_0_0_1_1_0_00_00_00;
  localparam logic [16:0] V_JUMP  = 17'b1_0_1_0_0_0_0_0_0_0_0_00_00_10;

  function automatic logic [16:0] v_branch(input logic z);
    return {2'b01, z, 8'b0000_0001, 6'b00_01_01};
  endfunction

  function automatic logic [16:0] observed();
    return {pc_wr, pc_wr_cond, pc_load, addr_sel_data, mem_rd, mem_wr, ir_wr,
            wb_sel_mem, reg_wr, dst_sel_rd, alu_a_sel_reg, alu_b_sel, alu_op, pc_src};
  endfunction

  task automatic check(input logic [16:0] exp, input string req);
    n_chk++;
    if (observed() !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, observed(), exp);
    end
  endtask

  task automatic run_seq(input logic [5:0] op, input logic z, input int n,
                         input logic [16:0] e0, input logic [16:0] e1,
                         input logic [16:0] e2, input logic [16:0] e3,
                         input logic [16:0] e4, input string req);
    logic [16:0] exp;
    opcode = op;
    alu_zero = z;
    #0.5;
    for (int i = 0; i < n; i++) begin
      case (i)
        0: exp = e0;
        1: exp = e1;
        2: exp = e2;
        3: exp = e3;
        default: exp = e4;
      endcase
      if (i > 0) begin
        @(negedge clk);
        #1;
      end
      check(exp, req);
    end
    @(negedge clk);
    #1;
    check(V_FETCH, {req, " cycle count"});
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check(V_FETCH, "R1 reset");
    rst = 1'b0;
    #0.5;
    check(V_FETCH, "R2 fetch after reset");
  endtask

  task automatic t_load(input logic z);
    run_seq(6'b100011, z, 5, V_FETCH, V_DEC, V_ADDR, V_LOAD, V_LWB,
            z ? "R4 load, R10 zero ignored" : "R4 load");
  endtask

  task automatic t_store();
    run_seq(6'b101011, 1'b1, 4, V_FETCH, V_DEC, V_ADDR, V_STORE, '0, "R5 store");
  endtask

  task automatic t_rtype();
    run_seq(6'b000000, 1'b1, 4, V_FETCH, V_DEC, V_EXEC, V_AWB, '0, "R6 r-type");
  endtask

  task automatic t_branch(input logic z);
    run_seq(6'b000100, z, 3, V_FETCH, V_DEC, v_branch(z), '0, '0,
            z ? "R7 branch taken" : "R7 branch not taken");
  endtask

  task automatic t_jump();
    run_seq(6'b000010, 1'b0, 3, V_FETCH, V_DEC, V_JUMP, '0, '0, "R8 jump");
  endtask

  task automatic t_unknown(input logic [5:0] op);
    run_seq(op, 1'b1, 2, V_FETCH, V_DEC, '0, '0, '0, "R9 unknown opcode");
  endtask

  task automatic t_reset_mid();
    opcode = 6'b100011;
    alu_zero = 1'b0;
    #0.5;
    check(V_FETCH, "R3 start of interrupted load");
    @(negedge clk); #1;
    check(V_DEC, "R3 decode of interrupted load");
    @(negedge clk); #1;
    check(V_ADDR, "R4 address of interrupted load");
    rst = 1'b1;
    @(negedge clk); #1;
    check(V_FETCH, "R1 reset mid-instruction");
    @(negedge clk); #1;
    check(V_FETCH, "R1 held in reset");
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_load(1'b0);
    t_load(1'b1);
    t_store();
    t_rtype();
    t_branch(1'b1);
    t_branch(1'b0);
    t_jump();
    t_unknown(6'b111111);
    t_unknown(6'b001000);
    t_reset_mid();
    t_jump();
    t_rtype();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule